// File: doc/BRIEF.md
# ECC Error Capture and Report Register

This block sits beside a memory controller's ECC checker and keeps a record of the first memory read error it is told about. The checker raises one of two strobes: one for a corrected single-bit error, one for an uncorrectable multi-bit error. With the strobe it supplies the failing address and the 8-bit syndrome. The block logs the kind of error, the upper part of the address and the syndrome into one 32-bit register. That record then stays frozen until software acknowledges it.

The same register word holds three control bits that software can read and write. The first suppresses scrub write-back of corrected data. The second lets a logged multi-bit error raise a bus-error line. The third lets a logged single-bit error raise a non-maskable interrupt request. To acknowledge an error, software must set both status bits in a single write. Any other write leaves the logged record as it is.

Top module: `ecc_err_log`

## Requirements
- R1: After a synchronous reset the register reads 0, `nmi_req` and `bus_err` are 0, and `scrub_en` is 1.
- R2: A write sets bit 31 (scrub off), bit 3 (bus-error enable) and bit 2 (NMI enable) from the write data. Write data in bits 30:4 is ignored.
- R3: When no error is logged, a single-bit strobe sets bit 0. In the same cycle the register stores address bits 31:13 into bits 30:12 and the syndrome into bits 11:4. The new contents are readable in the next cycle.
- R4: While bit 0 or bit 1 is set, no strobe changes bits 30:0 except through the control fields. This includes a strobe that arrives in the same cycle as the clearing write.
- R5: A write that sets only one of bits 1:0 leaves both status bits, the address field and the syndrome field unchanged.
- R6: A write with bits 1:0 both set clears both status bits. The next strobe after that is logged.
- R7: When no error is logged, a multi-bit strobe sets bit 1 and logs the address and syndrome in the same way as R3.
- R8: If both strobes arrive together while no error is logged, only bit 1 is set.
- R9: `nmi_req` equals (bit 0 AND bit 2) as the register held one cycle earlier.
- R10: `bus_err` equals (bit 1 AND bit 3) as the register held one cycle earlier.
- R11: `scrub_en` equals the inverse of bit 31 as the register held one cycle earlier.
- R12: Writing 0 to bits 1:0 does not change the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sbe_evt | input | 1 | Corrected single-bit error strobe |
| mbe_evt | input | 1 | Uncorrectable multi-bit error strobe |
| err_addr | input | 32 | Address of the failing read |
| err_syn | input | 8 | ECC syndrome of the failing read |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register contents |
| nmi_req | output | 1 | Non-maskable interrupt request |
| bus_err | output | 1 | Bus error request |
| scrub_en | output | 1 | Permission to write corrected data back |

## Verification
The assertions assume that the strobes, address and syndrome are stable and valid at the clock edge. They also assume that a register write and an error strobe can occur in the same cycle in any combination. The bench changes every input only on the falling clock edge. Its stimulus covers single strobes, simultaneous strobes, strobes that coincide with a clearing write, and writes that set only one status bit. Each case is checked against a register model kept in the bench.

// File: rtl/eel_pkg.sv
package eel_pkg;
  typedef enum logic [1:0] {
    ERR_NONE = 2'b00,
    ERR_SBE  = 2'b01,
    ERR_MBE  = 2'b10
  } err_kind_t;

  typedef struct packed {
    logic scrub_off;
    logic berr_en;
    logic nmi_en;
  } ctl_t;
endpackage

// File: rtl/eel_ctrl.sv
module eel_ctrl
  import eel_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  ctl_t wr_ctl,
  output ctl_t ctl_q
);
  always_ff @(posedge clk) begin
    if (rst)     ctl_q <= '0;
    else if (we) ctl_q <= wr_ctl;
  end
endmodule

// File: rtl/eel_capture.sv
module eel_capture
  import eel_pkg::*;
#(
  parameter int KEEP_W = 19,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sbe_evt,
  input  logic              mbe_evt,
  input  logic [KEEP_W-1:0] addr_hi,
  input  logic [SYN_W-1:0]  syn,
  input  logic              clr_req,
  output err_kind_t         kind_q,
  output logic [KEEP_W-1:0] addr_q,
  output logic [SYN_W-1:0]  syn_q
);
  logic logged;
  assign logged = (kind_q != ERR_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= ERR_NONE;
      addr_q <= '0;
      syn_q  <= '0;
    end else if (logged) begin
      if (clr_req) kind_q <= ERR_NONE;
    end else if (mbe_evt || sbe_evt) begin
      kind_q <= mbe_evt ? ERR_MBE : ERR_SBE;
      addr_q <= addr_hi;
      syn_q  <= syn;
    end
  end

  // R8
  mbe_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!logged && mbe_evt && sbe_evt) |=> (kind_q == ERR_MBE));
  // R4
  hold_record_chk: assert property (@(posedge clk) disable iff (rst)
    (logged && !clr_req) |=> ($stable(kind_q) && $stable(addr_q) && $stable(syn_q)));
  // R6
  clear_done_chk: assert property (@(posedge clk) disable iff (rst)
    (logged && clr_req) |=> (kind_q == ERR_NONE));
endmodule

// File: rtl/eel_signal.sv
module eel_signal
  import eel_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  err_kind_t kind,
  input  ctl_t      ctl,
  output logic      nmi_req,
  output logic      bus_err,
  output logic      scrub_en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_req  <= 1'b0;
      bus_err  <= 1'b0;
      scrub_en <= 1'b1;
    end else begin
      nmi_req  <= (kind == ERR_SBE) && ctl.nmi_en;
      bus_err  <= (kind == ERR_MBE) && ctl.berr_en;
      scrub_en <= !ctl.scrub_off;
    end
  end

  // R9
  nmi_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.nmi_en |=> !nmi_req);
  // R10
  berr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.berr_en |=> !bus_err);
  // R11
  scrub_off_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.scrub_off |=> !scrub_en);
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import eel_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SYN_W  = 8,
  parameter int KEEP_W = 19,
  localparam int REG_W = 1 + KEEP_W + SYN_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sbe_evt,
  input  logic              mbe_evt,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              nmi_req,
  output logic              bus_err,
  output logic              scrub_en
);
  localparam int DROP_W = ADDR_W - KEEP_W;

  ctl_t              wr_ctl, ctl_q;
  err_kind_t         kind_q;
  logic [KEEP_W-1:0] addr_q;
  logic [SYN_W-1:0]  syn_q;
  logic              clr_req;
  logic              unused_bits;

  assign wr_ctl.scrub_off = reg_wdata[REG_W-1];
  assign wr_ctl.berr_en   = reg_wdata[3];
  assign wr_ctl.nmi_en    = reg_wdata[2];
  assign clr_req          = reg_we && reg_wdata[1] && reg_wdata[0];
  assign unused_bits      = ^{reg_wdata[REG_W-2:4], err_addr[DROP_W-1:0]};

  eel_ctrl u_ctrl (
    .clk(clk), .rst(rst), .we(reg_we), .wr_ctl(wr_ctl), .ctl_q(ctl_q)
  );

  eel_capture #(.KEEP_W(KEEP_W), .SYN_W(SYN_W)) u_cap (
    .clk(clk), .rst(rst), .sbe_evt(sbe_evt), .mbe_evt(mbe_evt),
    .addr_hi(err_addr[ADDR_W-1 -: KEEP_W]), .syn(err_syn),
    .clr_req(clr_req), .kind_q(kind_q), .addr_q(addr_q), .syn_q(syn_q)
  );

  eel_signal u_sig (
    .clk(clk), .rst(rst), .kind(kind_q), .ctl(ctl_q),
    .nmi_req(nmi_req), .bus_err(bus_err), .scrub_en(scrub_en)
  );

  assign reg_rdata = {ctl_q.scrub_off, addr_q, syn_q, ctl_q.berr_en,
                      ctl_q.nmi_en, kind_q == ERR_MBE, kind_q == ERR_SBE};

  // R5
  half_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && (reg_wdata[1] != reg_wdata[0]) && kind_q != ERR_NONE)
      |=> $stable(kind_q));
  // R12
  zero_write_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_wdata[1:0] == 2'b00 && kind_q != ERR_NONE) |=> $stable(kind_q));
endmodule

// File: tb/ecc_err_log_bench.sv
module ecc_err_log_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sbe_evt = 1'b0, mbe_evt = 1'b0, reg_we = 1'b0;
  logic [31:0] err_addr = '0, reg_wdata = '0, reg_rdata;
  logic [7:0]  err_syn = '0;
  logic        nmi_req, bus_err, scrub_en;

  always #2.5 clk = ~clk;

  ecc_err_log u_ecc_err_log (
    .clk(clk), .rst(rst), .sbe_evt(sbe_evt), .mbe_evt(mbe_evt),
    .err_addr(err_addr), .err_syn(err_syn), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_req(nmi_req),
    .bus_err(bus_err), .scrub_en(scrub_en)
  );

  typedef struct {
    logic [31:0] rd;
    logic        n, b, s;
    string       tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  logic        m_sdis = 0, m_ben = 0, m_nen = 0, m_sf = 0, m_mf = 0;
  logic [18:0] m_addr = '0;
  logic [7:0]  m_syn = '0;

  function automatic logic [31:0] model_rd();
    return {m_sdis, m_addr, m_syn, m_ben, m_nen, m_mf, m_sf};
  endfunction

  task automatic compare(exp_t e);
    checks++;
    if (reg_rdata !== e.rd || nmi_req !== e.n || bus_err !== e.b || scrub_en !== e.s) begin
      errors++;
      $display("FAIL %s: rd=%h nmi=%b berr=%b scrub=%b expected rd=%h nmi=%b berr=%b scrub=%b",
               e.tag, reg_rdata, nmi_req, bus_err, scrub_en, e.rd, e.n, e.b, e.s);
    end
  endtask

  // monitor: pops one expected item per falling edge
  always @(negedge clk) begin
    if (q.size() > 0) compare(q.pop_front());
  end

  task automatic step(input logic s, input logic m, input logic [31:0] a,
                      input logic [7:0] y, input logic we, input logic [31:0] wd,
                      input string tag);
    exp_t e;
    logic logged;
    @(negedge clk);
    sbe_evt = s; mbe_evt = m; err_addr = a; err_syn = y; reg_we = we; reg_wdata = wd;
    e.n = m_sf & m_nen;
    e.b = m_mf & m_ben;
    e.s = !m_sdis;
    e.tag = tag;
    logged = m_sf | m_mf;
    if (logged) begin
      if (we && wd[1] && wd[0]) begin m_sf = 0; m_mf = 0; end
    end else if (m || s) begin
      m_mf = m; m_sf = !m; m_addr = a[31:13]; m_syn = y;
    end
    if (we) begin m_sdis = wd[31]; m_ben = wd[3]; m_nen = wd[2]; end
    e.rd = model_rd();
    @(posedge clk);
    #1 q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 32'h0, 8'h0, 0, 32'h0, tag);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r.rd = 32'h0; r.n = 0; r.b = 0; r.s = 1; r.tag = "R1 reset";
    compare(r);
    rst = 1'b0;
    step(0, 0, 0, 0, 1, 32'hFFFF_FFFC, "R2 control write, ro bits ignored");
    idle("R11 scrub off seen");
    step(0, 0, 0, 0, 1, 32'h0000_000C, "R11 scrub back on");
    step(1, 0, 32'hDEAD_B000, 8'h5A, 0, 0, "R3 single-bit capture");
    idle("R9 nmi raised");
    step(1, 0, 32'h1234_5678, 8'h11, 0, 0, "R4 second sbe ignored");
    step(0, 1, 32'h8765_4321, 8'h22, 0, 0, "R4 mbe ignored while logged");
    step(0, 0, 0, 0, 1, 32'h0000_000D, "R5 bit0 alone no clear");
    step(0, 0, 0, 0, 1, 32'h0000_000E, "R5 bit1 alone no clear");
    step(0, 0, 0, 0, 1, 32'h0000_000C, "R12 zero status write");
    step(0, 0, 0, 0, 1, 32'h0000_000F, "R6 full clear");
    idle("R9 nmi dropped");
    step(0, 1, 32'hFFFF_E000, 8'hC3, 0, 0, "R7 multi-bit capture");
    idle("R10 bus error raised");
    step(1, 0, 32'h0000_2000, 8'h01, 1, 32'h0000_000F, "R4 event during clear dropped");
    idle("R6 cleared, idle");
    step(1, 1, 32'hA5A5_A5A5, 8'h7E, 0, 0, "R8 simultaneous, mbe wins");
    idle("R10 bus error from simultaneous");
    step(0, 0, 0, 0, 1, 32'h0000_0003, "R6 clear and disable");
    step(1, 0, 32'h0F0F_0000, 8'h99, 0, 0, "R3 sbe with nmi disabled");
    idle("R9 no nmi when disabled");
    step(0, 0, 0, 0, 1, 32'h0000_0003, "R6 clear again");
    step(0, 1, 32'h4000_0000, 8'h44, 0, 0, "R7 mbe with berr disabled");
    idle("R10 no bus error when disabled");
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule